// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block takes level-sensitive interrupt lines from a configurable number of device sources and routes them to a set of target contexts. There are two contexts per hardware thread: machine mode and supervisor mode. Context number c is hart×2 + mode, where mode 0 is machine and mode 1 is supervisor. Every source has a programmable priority. Every context has its own enable bitmap, a priority threshold, a claim/complete register and one interrupt-request output.

A handler reads the claim register of its context. The read returns the best eligible source and moves that source from pending to in service. When the handler is done, it writes the same ID back to the same register, which releases the source. Source ID 0 is reserved and means "nothing to claim".

All registers are reached through a word-addressed request port. Word address W corresponds to byte offset 4×W in a 0x4000000-byte window. The port has a small two-state machine:

- BUS_IDLE accepts a request. A write takes effect at the accepting edge and the machine stays in BUS_IDLE. A read takes the transition IDLE→RESP.
- BUS_RESP presents the read data for one cycle and then takes RESP→IDLE.

Top module: `pintc_top`

## Requirements
- R1: After reset all priorities, enables and thresholds are 0, no source is pending or in service, every `irq_o` bit is low, `req_ready_o` is high and `rd_valid_o` is low.
- R2: The priority of source ID (1..NUM_SRC) is at word address ID (byte 4×ID) and holds PRIO_W bits that read back zero-extended. Word 0 and words above NUM_SRC in that region read 0 and ignore writes.
- R3: The pending bit of source ID is read at word 0x400 + (ID>>5), bit ID&31. A high source line that is not in service sets the bit at the next clock edge. The bit stays set until that source is claimed, even if the line falls first, and writes to these words are ignored.
- R4: The enable bit of source ID for context c is at word 0x800 + 32×c + (ID>>5), bit ID&31, is read/write, and resets to 0 (disabled).
- R5: The threshold of context c is at word 0x80000 + 0x400×c and its claim/complete register is at the following word. Contexts are numbered hart×2 + mode, with mode 0 machine and mode 1 supervisor.
- R6: A source is eligible for context c only when it is pending, enabled for c, and its priority is strictly greater than c's threshold. `irq_o[c]` is high exactly when some source is eligible for c, so priority 0 never interrupts.
- R7: A claim read returns the ID of the eligible source with the highest priority, the lowest ID among equal priorities, or 0 when none is eligible.
- R8: A claim read that returns a nonzero ID clears that source's pending bit and marks it in service. While in service the source does not become pending again, even with its line high.
- R9: Writing the ID of an in-service source to a claim/complete register ends its service. A line still high then makes it pending one edge later. A completion naming a source that is not in service is ignored.
- R10: Reserved addresses read as 0 and ignore writes. These include pending or enable words beyond the last source, enable words of non-existent contexts, and context words other than threshold and claim.
- R11: A read is accepted when `req_i` is high with `req_ready_o` high. `rd_valid_o` is then high with the data for exactly the next cycle, during which `req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NUM_SRC | Level interrupt lines; bit i is source ID i (range NUM_SRC:1) |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Port can accept a request (BUS_IDLE) |
| rd_valid_o | output | 1 | Read data valid (BUS_RESP) |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 2×NUM_HARTS | Interrupt request per context |

## Verification
Results arrive on a fixed schedule:

- A write takes effect at the edge that accepts it, so `irq_o` reflects a new enable, threshold or priority in the following low clock phase.
- A source line change reaches the pending bit one edge later, and `irq_o` follows in that same phase.
- Read data appears in the cycle after acceptance. A claim's pending-bit clear and the matching drop of `irq_o` are both visible in that response cycle.
- A completion re-arms a still-high line one edge after the write.

The bench drives inputs and samples outputs only on falling edges. It schedules every check at or after these points, and adds one idle cycle wherever the re-arm edge must pass before a read.

// File: rtl/pintc_pkg.sv
package pintc_pkg;
    localparam int unsigned PEND_BASE  = 'h400;
    localparam int unsigned EN_BASE    = 'h800;
    localparam int unsigned EN_STRIDE  = 32;
    localparam int unsigned CTX_BASE   = 'h80000;
    localparam int unsigned CTX_STRIDE = 'h400;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/pintc_gateway.sv
module pintc_gateway #(
    parameter int unsigned SRC_W = 5,
    parameter int unsigned ID    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic             claim_stb_i,
    input  logic [SRC_W-1:0] claim_id_i,
    input  logic             done_stb_i,
    input  logic [SRC_W-1:0] done_id_i,
    output logic             pend_o,
    output logic             busy_o
);
    localparam logic [SRC_W-1:0] MY_ID = SRC_W'(ID);

    logic pend_q, busy_q, claim_hit, done_hit;

    assign claim_hit = claim_stb_i && (claim_id_i == MY_ID);
    assign done_hit  = done_stb_i && (done_id_i == MY_ID);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else if (claim_hit) begin
            pend_q <= 1'b0;
            busy_q <= 1'b1;
        end else begin
            if (done_hit && busy_q)
                busy_q <= 1'b0;
            if (level_i && !busy_q)
                pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;
    assign busy_o = busy_q;

    // R8
    claim_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_hit |=> (!pend_o && busy_o));
    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_hit && busy_o && !claim_hit) |=> !busy_o);
    // R3
    level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i && !busy_o && !claim_hit) |=> pend_o);
endmodule

// File: rtl/pintc_arbiter.sv
module pintc_arbiter #(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned SRC_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC:1]                pend_i,
    input  logic [NSRC:1]                en_i,
    input  logic [NSRC:1][PRIO_W-1:0]    prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [SRC_W-1:0]             best_o,
    output logic                         hit_o
);
    logic [PRIO_W-1:0] best_p;
    logic [SRC_W-1:0]  best_id;

    // Scan upward with a strict compare: equal priorities keep the lower ID.
    always_comb begin
        best_p  = thr_i;
        best_id = '0;
        for (int i = 1; i <= int'(NSRC); i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
                best_p  = prio_i[i];
                best_id = SRC_W'(i);
            end
        end
    end

    assign best_o = best_id;
    assign hit_o  = (best_id != '0);

    // R6
    win_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (pend_i[best_o] && en_i[best_o] && (prio_i[best_o] > thr_i)));
    // R6
    prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (prio_i[best_o] != '0));
endmodule

// File: rtl/pintc_top.sv
module pintc_top #(
    parameter int unsigned NUM_SRC   = 31,
    parameter int unsigned NUM_HARTS = 1,
    parameter int unsigned PRIO_W    = 3,
    parameter int unsigned ADDR_W    = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC:1]           src_irq,
    input  logic                       req_i,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [31:0]                wdata_i,
    output logic                       req_ready_o,
    output logic                       rd_valid_o,
    output logic [31:0]                rd_data_o,
    output logic [2*NUM_HARTS-1:0]     irq_o
);
    import pintc_pkg::*;

    localparam int unsigned NCTX   = 2 * NUM_HARTS;
    localparam int unsigned SRC_W  = $clog2(NUM_SRC + 1);
    localparam int unsigned NWORDS = (NUM_SRC + 32) / 32;

    bus_state_e state_q, state_d;

    logic [NUM_SRC:1][PRIO_W-1:0]  prio_q;
    logic [NCTX-1:0][NUM_SRC:1]    en_q;
    logic [NCTX-1:0][PRIO_W-1:0]   thr_q;
    logic [31:0]                   rdata_q;

    logic [NUM_SRC:1]              pend, busy;
    logic [SRC_W-1:0]              best [NCTX];
    logic [NCTX-1:0]               hit;

    int unsigned a, en_ctx, en_word, c_ctx, c_sub;
    logic sel_prio, sel_pend, sel_en, sel_ctx, sel_thr, sel_clm;
    logic accept;
    logic claim_stb, done_stb;
    logic [SRC_W-1:0] claim_id, done_id;
    logic [31:0] rd_word;

    // ---------------- address decode ----------------
    always_comb begin
        a        = 32'(addr_i);
        sel_prio = (a >= 1) && (a <= NUM_SRC);
        sel_pend = (a >= PEND_BASE) && (a < PEND_BASE + NWORDS);
        en_ctx   = (a - EN_BASE) / EN_STRIDE;
        en_word  = (a - EN_BASE) % EN_STRIDE;
        sel_en   = (a >= EN_BASE) && (a < EN_BASE + NCTX * EN_STRIDE) && (en_word < NWORDS);
        c_ctx    = (a - CTX_BASE) / CTX_STRIDE;
        c_sub    = (a - CTX_BASE) % CTX_STRIDE;
        sel_ctx  = (a >= CTX_BASE) && (a < CTX_BASE + NCTX * CTX_STRIDE);
        sel_thr  = sel_ctx && (c_sub == 0);
        sel_clm  = sel_ctx && (c_sub == 1);
    end

    assign accept = req_i && (state_q == BUS_IDLE);

    // ---------------- read data mux ----------------
    always_comb begin
        rd_word = '0;
        if (sel_prio) begin
            rd_word = 32'(prio_q[a]);
        end else if (sel_pend) begin
            for (int b = 0; b < 32; b++)
                if (((a - PEND_BASE) * 32 + b >= 1) && ((a - PEND_BASE) * 32 + b <= NUM_SRC))
                    rd_word[b] = pend[(a - PEND_BASE) * 32 + b];
        end else if (sel_en) begin
            for (int b = 0; b < 32; b++)
                if ((en_word * 32 + b >= 1) && (en_word * 32 + b <= NUM_SRC))
                    rd_word[b] = en_q[en_ctx][en_word * 32 + b];
        end else if (sel_thr) begin
            rd_word = 32'(thr_q[c_ctx]);
        end else if (sel_clm) begin
            rd_word = 32'(best[c_ctx]);
        end
    end

    // ---------------- claim / complete strobes ----------------
    always_comb begin
        claim_id  = sel_clm ? best[c_ctx] : '0;
        claim_stb = accept && !we_i && sel_clm && (claim_id != '0);
        done_id   = SRC_W'(wdata_i);
        done_stb  = accept && we_i && sel_clm && (wdata_i <= NUM_SRC) && (wdata_i != 0);
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q  <= '0;
            en_q    <= '0;
            thr_q   <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            if (we_i) begin
                if (sel_prio)
                    prio_q[a] <= wdata_i[PRIO_W-1:0];
                if (sel_thr)
                    thr_q[c_ctx] <= wdata_i[PRIO_W-1:0];
                if (sel_en) begin
                    for (int b = 0; b < 32; b++)
                        if ((en_word * 32 + b >= 1) && (en_word * 32 + b <= NUM_SRC))
                            en_q[en_ctx][en_word * 32 + b] <= wdata_i[b];
                end
            end else begin
                rdata_q <= rd_word;
            end
        end
    end

    // ---------------- bus state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (accept && !we_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        req_ready_o = (state_q == BUS_IDLE);
        rd_valid_o  = (state_q == BUS_RESP);
        rd_data_o   = rd_valid_o ? rdata_q : '0;
    end

    // ---------------- per-source gateways ----------------
    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        pintc_gateway #(.SRC_W(SRC_W), .ID(s)) gw_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .level_i     (src_irq[s]),
            .claim_stb_i (claim_stb),
            .claim_id_i  (claim_id),
            .done_stb_i  (done_stb),
            .done_id_i   (done_id),
            .pend_o      (pend[s]),
            .busy_o      (busy[s])
        );
    end

    // ---------------- per-context arbiters ----------------
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        pintc_arbiter #(.NSRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) arb_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend),
            .en_i   (en_q[c]),
            .prio_i (prio_q),
            .thr_i  (thr_q[c]),
            .best_o (best[c]),
            .hit_o  (hit[c])
        );
    end

    assign irq_o = hit;

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && req_ready_o && !we_i) |=> (rd_valid_o && !req_ready_o));
    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);
    // R8
    no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & busy) == '0);
endmodule

// File: tb/pintc_top_tb_top.sv
module pintc_top_tb_top;
    localparam int unsigned NSRC = 31;
    localparam int unsigned CLM0 = 'h80001;
    localparam int unsigned CLM1 = 'h80401;
    localparam int unsigned THR0 = 'h80000;
    localparam int unsigned THR1 = 'h80400;
    localparam int unsigned EN0  = 'h800;
    localparam int unsigned EN1  = 'h820;
    localparam int unsigned PND  = 'h400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC:1] src_irq = '0;
    logic req_i = 1'b0, we_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic req_ready_o, rd_valid_o;
    logic [31:0] rd_data_o;
    logic [1:0] irq_o;

    int nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    pintc_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .req_ready_o(req_ready_o),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input int unsigned ad, input logic [31:0] d);
        req_i = 1'b1; we_i = 1'b1; addr_i = 24'(ad); wdata_i = d;
        @(posedge clk); @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd(input int unsigned ad, output logic [31:0] d);
        req_i = 1'b1; we_i = 1'b0; addr_i = 24'(ad);
        @(posedge clk); @(negedge clk);
        req_i = 1'b0;
        chk("R11 valid/ready in response", {30'd0, rd_valid_o, req_ready_o}, 32'h2);
        d = rd_data_o;
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", 32'(irq_o), 0);
        chk("R1 ready after reset", {31'd0, req_ready_o}, 1);
        chk("R1 rd_valid after reset", {31'd0, rd_valid_o}, 0);
        rd(5, d);    chk("R1 priority 5", d, 0);
        rd(EN0, d);  chk("R1 enable ctx0", d, 0);
        rd(THR1, d); chk("R1 threshold ctx1", d, 0);
        rd(CLM0, d); chk("R1 claim empty", d, 0);
        rd(PND, d);  chk("R1 pending", d, 0);
    endtask

    task automatic t_prio_regs();
        logic [31:0] d;
        wr(3, 5);             rd(3, d);  chk("R2 prio 3 readback", d, 5);
        wr(7, 32'hFFFF_FFFF); rd(7, d);  chk("R2 prio width", d, 7);
        wr(0, 7);             rd(0, d);  chk("R2 id0 word", d, 0);
        wr(32, 7);            rd(32, d); chk("R10 prio beyond last source", d, 0);
        wr(3, 0); wr(7, 0);
    endtask

    task automatic t_gate_and_claim();
        logic [31:0] d;
        wr(4, 2);
        src_irq[4] = 1'b1; tick();
        rd(PND, d); chk("R3 pending bit 4", d, 32'h10);
        chk("R6 not enabled -> no irq", 32'(irq_o), 0);
        wr(PND, 0); rd(PND, d); chk("R3 pending write ignored", d, 32'h10);
        wr(EN0, 32'h10); rd(EN0, d); chk("R4 enable readback", d, 32'h10);
        chk("R6 irq ctx0 only", 32'(irq_o), 1);
        wr(THR0, 2); chk("R6 threshold equal blocks", 32'(irq_o), 0);
        wr(THR0, 1); chk("R6 threshold below passes", 32'(irq_o), 1);
        src_irq[4] = 1'b0; tick();
        rd(PND, d); chk("R3 pending held after line drop", d, 32'h10);
        rd(CLM0, d); chk("R7 claim single", d, 4);
        chk("R8 irq drops after claim", 32'(irq_o), 0);
        rd(PND, d); chk("R8 pending cleared by claim", d, 0);
        wr(CLM0, 4); tick();
        rd(PND, d); chk("R9 low line not re-pended", d, 0);
        wr(THR0, 0); wr(EN0, 0); wr(4, 0);
    endtask

    task automatic t_arbitrate();
        logic [31:0] d;
        wr(9, 3); wr(12, 3); wr(20, 6);
        wr(EN0, (32'd1 << 9) | (32'd1 << 12) | (32'd1 << 20));
        src_irq[9] = 1'b1; src_irq[12] = 1'b1; src_irq[20] = 1'b1; tick();
        rd(CLM0, d); chk("R7 highest priority wins", d, 20);
        rd(CLM0, d); chk("R7 tie to lowest id", d, 9);
        rd(CLM0, d); chk("R7 remaining source", d, 12);
        rd(CLM0, d); chk("R7 none eligible", d, 0);
        rd(PND, d);  chk("R8 in-service lines stay unpended", d, 0);
        wr(CLM0, 9); tick();
        rd(PND, d);  chk("R9 completion re-arms high line", d, 32'd1 << 9);
        src_irq = '0;
        wr(CLM0, 20); wr(CLM0, 12);
        rd(CLM0, d); chk("R7 re-armed source claimed", d, 9);
        wr(CLM0, 9);
        wr(9, 0); wr(12, 0); wr(20, 0); wr(EN0, 0);
    endtask

    task automatic t_stray_complete();
        logic [31:0] d;
        wr(6, 1); wr(EN0, 32'd1 << 6);
        src_irq[6] = 1'b1; tick();
        rd(CLM0, d); chk("R7 claim source 6", d, 6);
        wr(CLM0, 7); tick();
        rd(PND, d); chk("R9 stray completion ignored", d, 0);
        wr(CLM0, 6); tick();
        rd(PND, d); chk("R9 matching completion", d, 32'd1 << 6);
        src_irq[6] = 1'b0;
        rd(CLM0, d); wr(CLM0, 6);
        wr(6, 0); wr(EN0, 0);
    endtask

    task automatic t_context1();
        logic [31:0] d;
        wr(15, 4); wr(EN1, 32'd1 << 15); wr(THR1, 3);
        rd(THR1, d); chk("R5 ctx1 threshold readback", d, 3);
        rd(EN0, d);  chk("R5 ctx0 enable untouched", d, 0);
        src_irq[15] = 1'b1; tick();
        chk("R5 irq on supervisor context", 32'(irq_o), 2);
        rd(CLM0, d); chk("R5 ctx0 claim empty", d, 0);
        rd(CLM1, d); chk("R5 ctx1 claim", d, 15);
        src_irq[15] = 1'b0;
        wr(CLM1, 15);
        wr(15, 0); wr(EN1, 0); wr(THR1, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        rd(PND + 1, d); chk("R10 pending beyond last word", d, 0);
        wr('h80002, 32'hDEAD); rd('h80002, d); chk("R10 context gap", d, 0);
        rd('h1234, d); chk("R10 unmapped hole", d, 0);
        wr(EN0 + 64, 32'hFFFF_FFFF); rd(EN0 + 64, d); chk("R10 absent context enable", d, 0);
        wr(EN0 + 1, 32'hFFFF_FFFF); rd(EN0 + 1, d); chk("R10 enable beyond last word", d, 0);
        chk("R10 no irq from reserved writes", 32'(irq_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prio_regs();
        t_gate_and_claim();
        t_arbitrate();
        t_stray_complete();
        t_context1();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule